// File: doc/BRIEF.md
# Single-Bit Bitstream Reader

The block pulls a packed bitstream out of a word-wide synchronous memory one bit at a time. It holds a word pointer and a bit position. Each read request picks one bit of the current word, by position, and returns it as a zero-extended word with a valid flag. The bit position then advances. When the last bit of a word has been consumed, the position returns to zero and the word pointer moves to the next word.

A client first loads a start address, which also rewinds the bit position to zero. From then on it may raise the read request on any cycle, including every cycle in a row. The block never stalls and has no ready signal, so the consumer of the result has no way to apply back-pressure. It must accept each result in the cycle it is flagged valid. The memory address driven on `mem_addr` always comes straight from the word pointer register. A word change caused by one read is therefore already on the address bus when the next request is sampled. The memory must return data exactly one cycle after it samples the address.

Top module: `bitrd_top`

## Requirements
- R1: While and after reset, `result_valid` is 0, `result_data` is 0 and `mem_addr` is 0, and the bit position is 0.
- R2: A load (`load_en` high at a rising edge) makes `mem_addr` equal `load_addr` from the following cycle, and the next read returns bit 0 of that word.
- R3: A read at edge t (`rd_req` high, `load_en` low) drives `result_valid` high during the cycle after t. In that cycle `result_data[0]` equals bit p of the word the memory returns for `mem_addr`, where p is the current bit position (bit 0 is the least significant bit), and `result_data[15:1]` is 0.
- R4: Each read raises the bit position by one. On a cycle with neither load nor read, `mem_addr` and the bit position hold.
- R5: The read that consumes bit 15 returns the position to 0 and raises `mem_addr` by one from the next cycle.
- R6: Reads on consecutive cycles each produce a valid result on consecutive cycles, with no stall and no skipped bit.
- R7: The word address wraps from 0xFFFF to 0x0000.
- R8: When `load_en` and `rd_req` are both high, the load takes effect and the read is dropped: no result is flagged in the next cycle.
- R9: `result_data` is 0 in every cycle in which `result_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load start word address and rewind bit position |
| load_addr | input | 16 | Start word address |
| rd_req | input | 1 | Request one bit |
| mem_addr | output | 16 | Word address to the synchronous memory |
| mem_rdata | input | 16 | Memory word, one cycle after its address was sampled |
| result_valid | output | 1 | Result present this cycle |
| result_data | output | 16 | Selected bit, zero-extended |

## Verification
A read sampled at a rising edge yields its result in the cycle that follows, and a load or a word change shows on `mem_addr` in that same cycle. The bench drives every input on the falling edge. It samples the outputs at the next falling edge, so each check looks at exactly the cycle in which the result of the stimulus just applied is due. The bench keeps its own word and position model and reads data from its own computed memory contents. It therefore predicts each bit, each valid flag and each address without reference to the design.

// File: rtl/bitrd_pkg.sv
`timescale 1ns/1ps
package bitrd_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_READ = 2'd1,
    CMD_LOAD = 2'd2
  } cmd_e;

  // load outranks read
  function automatic cmd_e decode_cmd(input logic load, input logic rd);
    if (load) return CMD_LOAD;
    if (rd) return CMD_READ;
    return CMD_IDLE;
  endfunction
endpackage

// File: rtl/bitrd_ptr.sv
`timescale 1ns/1ps
module bitrd_ptr
  import bitrd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned POS_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] word_addr,
  output logic [POS_W-1:0]  bit_pos
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_addr <= '0;
      bit_pos   <= '0;
    end else begin
      case (cmd)
        CMD_LOAD: begin
          word_addr <= load_addr;
          bit_pos   <= '0;
        end
        CMD_READ: begin
          if (bit_pos == LAST_POS) begin
            bit_pos   <= '0;
            word_addr <= word_addr + ADDR_W'(1);
          end else begin
            bit_pos <= bit_pos + POS_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bitrd_issue.sv
`timescale 1ns/1ps
module bitrd_issue
  import bitrd_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned POS_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [POS_W-1:0] bit_pos,
  output logic             pend_vld,
  output logic [POS_W-1:0] pend_sel
);
  // tracks the read whose word is in flight in the memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_sel <= '0;
    end else begin
      pend_vld <= (cmd == CMD_READ);
      if (cmd == CMD_READ) pend_sel <= bit_pos;
    end
  end
endmodule

// File: rtl/bitrd_pick.sv
`timescale 1ns/1ps
module bitrd_pick #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned POS_W = $clog2(WORD_W)
) (
  input  logic              vld,
  input  logic [POS_W-1:0]  sel,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] hit;

  for (genvar i = 0; i < WORD_W; i++) begin : g_hit
    assign hit[i] = word[i] & (sel == POS_W'(i));
  end

  always_comb begin
    result    = '0;
    result[0] = vld & (|hit);
  end
endmodule

// File: rtl/bitrd_top.sv
`timescale 1ns/1ps
module bitrd_top
  import bitrd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              rd_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              result_valid,
  output logic [WORD_W-1:0] result_data
);
  localparam int unsigned POS_W = $clog2(WORD_W);

  cmd_e             cmd;
  logic [POS_W-1:0] bit_pos;
  logic [POS_W-1:0] pend_sel;
  logic             pend_vld;

  assign cmd = decode_cmd(load_en, rd_req);

  bitrd_ptr #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .load_addr(load_addr),
    .word_addr(mem_addr), .bit_pos(bit_pos)
  );

  bitrd_issue #(.WORD_W(WORD_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bit_pos(bit_pos),
    .pend_vld(pend_vld), .pend_sel(pend_sel)
  );

  bitrd_pick #(.WORD_W(WORD_W)) u_pick (
    .vld(pend_vld), .sel(pend_sel), .word(mem_rdata), .result(result_data)
  );

  assign result_valid = pend_vld;
endmodule

// File: rtl/bitrd_chk.sv
`timescale 1ns/1ps
module bitrd_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_en,
  input logic [ADDR_W-1:0] load_addr,
  input logic              rd_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_rdata,
  input logic              result_valid,
  input logic [WORD_W-1:0] result_data
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R3
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (result_valid == $past(rd_req && !load_en)));

  // R9
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> (result_data == '0));

  // R3
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_data[WORD_W-1:1] == '0);

  // R2
  load_addr_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (mem_addr == $past(load_addr)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !rd_req) |=> $stable(mem_addr));

  // R5
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && rd_req) |=>
      (mem_addr == $past(mem_addr) || mem_addr == $past(mem_addr) + ADDR_W'(1)));
endmodule

bind bitrd_top bitrd_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/test_bitrd_top.sv
`timescale 1ns/1ps
module test_bitrd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [15:0] load_addr = '0;
  logic        rd_req = 1'b0;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        result_valid;
  logic [15:0] result_data;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  logic [15:0] m_word = '0;
  logic [3:0]  m_bit = '0;

  always #4 clk = ~clk;

  bitrd_top i_bitrd_top (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .rd_req(rd_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .result_valid(result_valid), .result_data(result_data)
  );

  function automatic logic [15:0] word_fn(input logic [15:0] a);
    logic [15:0] p;
    p = a * 16'h9E37;
    return p ^ 16'h5A3C;
  endfunction

  // synchronous memory, one cycle latency
  always @(posedge clk) mem_rdata <= word_fn(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, check the due results at the next one
  task automatic step(input logic ld, input logic rd, input logic [15:0] a,
                      input string req);
    logic        ev;
    logic [15:0] ed;
    logic [15:0] w;
    load_en = ld; rd_req = rd; load_addr = a;
    ev = 1'b0; ed = '0;
    if (ld) begin
      m_word = a; m_bit = '0;
    end else if (rd) begin
      w = word_fn(m_word);
      ev = 1'b1;
      ed = {15'b0, w[m_bit]};
      if (m_bit == 4'd15) m_word = m_word + 16'd1;
      m_bit = m_bit + 4'd1;
    end
    @(negedge clk);
    chk(result_valid == ev, {req, " valid"}, {15'b0, result_valid}, {15'b0, ev});
    chk(result_data == ed, {req, " data"}, result_data, ed);
    chk(mem_addr == m_word, {req, " addr"}, mem_addr, m_word);
  endtask

  // {load, read, load_addr, expected valid, expected mem_addr}
  localparam logic [34:0] VEC [8] = '{
    {1'b1, 1'b0, 16'h0010, 1'b0, 16'h0010},
    {1'b0, 1'b1, 16'h0000, 1'b1, 16'h0010},
    {1'b0, 1'b1, 16'h0000, 1'b1, 16'h0010},
    {1'b0, 1'b0, 16'h0000, 1'b0, 16'h0010},
    {1'b0, 1'b1, 16'h0000, 1'b1, 16'h0010},
    {1'b1, 1'b1, 16'h0020, 1'b0, 16'h0020},
    {1'b0, 1'b1, 16'h0000, 1'b1, 16'h0020},
    {1'b0, 1'b0, 16'h0000, 1'b0, 16'h0020}
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(result_valid == 1'b0, "R1 valid", {15'b0, result_valid}, 16'h0);
    chk(result_data == 16'h0, "R1 data", result_data, 16'h0);
    chk(mem_addr == 16'h0, "R1 addr", mem_addr, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R8 R9: table walk
    for (int i = 0; i < 8; i++) begin
      step(VEC[i][34], VEC[i][33], VEC[i][32:17], "R2/R3/R4/R8/R9 table");
      chk(result_valid == VEC[i][16], "R8 table valid", {15'b0, result_valid},
          {15'b0, VEC[i][16]});
      chk(mem_addr == VEC[i][15:0], "R2 table addr", mem_addr, VEC[i][15:0]);
    end

    // R5 R6: long back-to-back run across word boundaries
    step(1'b1, 1'b0, 16'h1234, "R2 load");
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 1'b1, 16'h0, "R6 back-to-back");
      if (i == 15) chk(mem_addr == 16'h1235, "R5 word step", mem_addr, 16'h1235);
    end
    step(1'b0, 1'b0, 16'h0, "R4 hold");
    step(1'b0, 1'b1, 16'h0, "R4 resume");

    // R7: address wrap
    step(1'b1, 1'b0, 16'hFFFF, "R7 load");
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 16'h0, "R7 reads");
    chk(mem_addr == 16'h0000, "R7 wrap", mem_addr, 16'h0000);
    step(1'b0, 1'b1, 16'h0, "R7 first bit after wrap");

    // R1: reset in the middle of a stream
    load_en = 1'b0; rd_req = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk(result_valid == 1'b0, "R1 mid valid", {15'b0, result_valid}, 16'h0);
    chk(mem_addr == 16'h0, "R1 mid addr", mem_addr, 16'h0);
    rd_req = 1'b0;
    rst_n = 1'b1;
    m_word = '0; m_bit = '0;
    @(negedge clk);
    step(1'b0, 1'b1, 16'h0, "R1 position zero after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule